// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns a single column command into the stream of per-beat column addresses that an SDRAM read or write burst walks through. A command carries a starting column, a burst length of 1, 2, 4 or 8 words, and a wrap order. The beats always stay inside the naturally aligned group of columns whose size equals the burst length. The requested column comes out first, so a cache line can be fetched critical word first.

One internal beat is launched per clock, starting in the cycle the command is presented. Each launched beat then travels through a delay line whose length is the programmed CAS latency. It appears on the outputs with a valid strobe and, on the final beat of a burst, a last flag. A new command may cut an active burst short. Its first beat is launched in its own command cycle, so its data follows directly behind the truncated earlier burst. A separate terminate input stops the active burst without starting another one. Row opening, refresh and the storage array are handled elsewhere.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `dq_valid` and `dq_last` are 0. Asserting reset during a burst discards every beat still in flight.
- R2: `cmd_len_code` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. An uninterrupted burst produces exactly that many valid beats on consecutive cycles. `dq_last` is 1 on the final beat only.
- R3: When `cmd_order` is 0 (sequential), beat i carries the column whose bits above log2(length) match the start column. Its low log2(length) bits equal (start + i) modulo the length.
- R4: When `cmd_order` is 1 (interleaved), beat i keeps the same upper bits. Its low log2(length) bits equal the start's low bits XOR i.
- R5: A command presented in cycle 0 with `cas_lat` = L gives its first valid beat in cycle L, and later beats in the cycles that follow. `cas_lat` must stay constant while beats are in flight.
- R6: A length-1 burst produces one valid beat, carrying the start column with `dq_last` set, and nothing after it.
- R7: A command that arrives while a burst is active abandons the remaining beats of the old burst. Its own first beat is launched in its command cycle, so its data immediately follows the old burst's last delivered beat.
- R8: `cmd_stop` held high in a cycle without `cmd_start` launches no beat in that cycle and ends the active burst. Beats already launched still come out, and none of them carries `dq_last`.
- R9: When `cmd_start` and `cmd_stop` are high in the same cycle, the start wins. The new burst runs to completion.
- R10: A `cas_lat` value of 0 behaves as a latency of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start a burst using the command fields this cycle |
| cmd_stop | input | 1 | Terminate the active burst |
| cmd_col | input | COL_W | Starting column of the burst |
| cmd_len_code | input | LEN_W | Burst length code (length = 2^code) |
| cmd_order | input | 1 | 0 sequential wrap, 1 interleaved wrap |
| cas_lat | input | CL_W | CAS latency in cycles |
| dq_valid | output | 1 | Beat data valid |
| dq_col | output | COL_W | Column of the current beat |
| dq_last | output | 1 | Final beat of a completed burst |

## Verification
The stimulus aims at the points where a wrong sequencer gives itself away:
- Start columns in the middle and at the top of their aligned group. A design that carried into the upper bits instead of wrapping would leave the group, and one that did not put the requested word first would emit the group base.
- Interleaved starts at odd offsets. These separate XOR ordering from addition.
- The smallest latency, a latency of 0 and the largest latency. These catch a delay line that is off by one stage.
- An interrupting command two cycles into a burst, a terminate in the middle of a burst, and a start and stop in the same cycle. These expose a launcher that keeps feeding beats from the old burst, drops the new first beat, or flags a truncated burst as complete.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_XOR = 1'b1
  } burst_order_e;

endpackage

// File: rtl/col_beat_gen.sv
module col_beat_gen #(
  parameter int COL_W = 10,
  parameter int IDX_W = 3,
  parameter int LEN_W = 2
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [IDX_W-1:0] beat_idx,
  input  logic [LEN_W-1:0] len_code,
  input  logic             order,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last
);
  import burst_col_pkg::*;

  logic [IDX_W-1:0] wrap_mask;
  logic [IDX_W-1:0] low_base;
  logic [IDX_W-1:0] low_seq;
  logic [IDX_W-1:0] low_xor;
  logic [IDX_W-1:0] low_pick;

  always_comb begin
    wrap_mask = ~({IDX_W{1'b1}} << len_code);
    low_base  = base_col[IDX_W-1:0];
    low_seq   = low_base + beat_idx;
    low_xor   = low_base ^ beat_idx;
    low_pick  = (burst_order_e'(order) == ORDER_XOR) ? low_xor : low_seq;
    beat_col  = {base_col[COL_W-1:IDX_W], (low_base & ~wrap_mask) | (low_pick & wrap_mask)};
    beat_last = (beat_idx == wrap_mask);
  end

endmodule

// File: rtl/burst_launcher.sv
module burst_launcher #(
  parameter int COL_W = 10,
  parameter int IDX_W = 3,
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [LEN_W-1:0] cmd_len_code,
  input  logic             cmd_order,
  output logic             launch_vld,
  output logic [COL_W-1:0] launch_col,
  output logic             launch_last
);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [COL_W-1:0] base_q;
  logic [LEN_W-1:0] code_q;
  logic             order_q;
  logic             load_en;

  logic [COL_W-1:0] sel_base;
  logic [IDX_W-1:0] sel_idx;
  logic [LEN_W-1:0] sel_code;
  logic             sel_order;

  always_comb begin
    sel_base  = cmd_start ? cmd_col      : base_q;
    sel_idx   = cmd_start ? '0           : idx_q;
    sel_code  = cmd_start ? cmd_len_code : code_q;
    sel_order = cmd_start ? cmd_order    : order_q;
  end

  col_beat_gen #(
    .COL_W(COL_W),
    .IDX_W(IDX_W),
    .LEN_W(LEN_W)
  ) beat_gen_i (
    .base_col (sel_base),
    .beat_idx (sel_idx),
    .len_code (sel_code),
    .order    (sel_order),
    .beat_col (launch_col),
    .beat_last(launch_last)
  );

  always_comb begin
    launch_vld = cmd_start | (busy_q & ~cmd_stop);
    load_en    = cmd_start;
    busy_d     = busy_q;
    idx_d      = idx_q;
    if (cmd_start) begin
      busy_d = ~launch_last;
      idx_d  = IDX_W'(1);
    end else if (cmd_stop) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      busy_d = ~launch_last;
      idx_d  = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      code_q  <= '0;
      order_q <= 1'b0;
    end else if (load_en) begin
      base_q  <= cmd_col;
      code_q  <= cmd_len_code;
      order_q <= cmd_order;
    end
  end

  logic [IDX_W-1:0] held_mask;
  logic [COL_W-1:0] group_keep;
  assign held_mask  = ~({IDX_W{1'b1}} << code_q);
  assign group_keep = ~COL_W'(held_mask);

  // R8: after a terminate, no beat follows unless a new command arrives
  assert_stop_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && !cmd_start) |=> (!launch_vld || cmd_start));

  // R2: the final beat of a burst is followed only by a new command's beat
  assert_last_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_vld && launch_last) |=> (!launch_vld || cmd_start));

  // R3/R4: continuation beats never leave the aligned group
  assert_group_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_vld && !cmd_start) |-> (((launch_col ^ $past(launch_col)) & group_keep) == '0));

  // R3: sequential continuation beats step by one modulo the length
  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_vld && !cmd_start && !order_q) |->
      (((launch_col[IDX_W-1:0] - $past(launch_col[IDX_W-1:0])) & held_mask) == (IDX_W'(1) & held_mask)));

endmodule

// File: rtl/cas_pipe.sv
module cas_pipe #(
  parameter int COL_W  = 10,
  parameter int MAX_CL = 7,
  parameter int CL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [COL_W-1:0] in_col,
  input  logic             in_last,
  input  logic [CL_W-1:0]  cas_lat,
  output logic             out_vld,
  output logic [COL_W-1:0] out_col,
  output logic             out_last
);

  logic             vld_q  [MAX_CL];
  logic [COL_W-1:0] col_q  [MAX_CL];
  logic             last_q [MAX_CL];

  for (genvar k = 0; k < MAX_CL; k++) begin : g_stage
    logic             src_vld;
    logic [COL_W-1:0] src_col;
    logic             src_last;

    if (k == 0) begin : g_head
      assign src_vld  = in_vld;
      assign src_col  = in_col;
      assign src_last = in_last;
    end else begin : g_tail
      assign src_vld  = vld_q[k-1];
      assign src_col  = col_q[k-1];
      assign src_last = last_q[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[k] <= 1'b0;
      end else begin
        vld_q[k] <= src_vld;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        col_q[k]  <= '0;
        last_q[k] <= 1'b0;
      end else if (src_vld) begin
        col_q[k]  <= src_col;
        last_q[k] <= src_last;
      end
    end
  end

  logic [CL_W-1:0] tap;

  always_comb begin
    if (cas_lat == '0) begin
      tap = '0;
    end else if (cas_lat > CL_W'(MAX_CL)) begin
      tap = CL_W'(MAX_CL - 1);
    end else begin
      tap = cas_lat - CL_W'(1);
    end
    out_vld  = vld_q[tap];
    out_col  = col_q[tap];
    out_last = vld_q[tap] & last_q[tap];
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W  = 10,
  parameter int MAX_BL = 8,
  parameter int MAX_CL = 7,
  localparam int IDX_W = $clog2(MAX_BL),
  localparam int LEN_W = $clog2(IDX_W + 1),
  localparam int CL_W  = $clog2(MAX_CL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [LEN_W-1:0] cmd_len_code,
  input  logic             cmd_order,
  input  logic [CL_W-1:0]  cas_lat,
  output logic             dq_valid,
  output logic [COL_W-1:0] dq_col,
  output logic             dq_last
);

  logic             launch_vld;
  logic [COL_W-1:0] launch_col;
  logic             launch_last;

  burst_launcher #(
    .COL_W(COL_W),
    .IDX_W(IDX_W),
    .LEN_W(LEN_W)
  ) launcher_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .cmd_stop    (cmd_stop),
    .cmd_col     (cmd_col),
    .cmd_len_code(cmd_len_code),
    .cmd_order   (cmd_order),
    .launch_vld  (launch_vld),
    .launch_col  (launch_col),
    .launch_last (launch_last)
  );

  cas_pipe #(
    .COL_W (COL_W),
    .MAX_CL(MAX_CL),
    .CL_W  (CL_W)
  ) pipe_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (launch_vld),
    .in_col  (launch_col),
    .in_last (launch_last),
    .cas_lat (cas_lat),
    .out_vld (dq_valid),
    .out_col (dq_col),
    .out_last(dq_last)
  );

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 10;
  localparam int NVEC  = 9;

  // vector table: start column, length code, order, latency, requirement tag
  localparam int    V_COL  [NVEC] = '{5, 'h2B, 'h3FF, 6, 'h12, 7, 3, 'h1F3, 9};
  localparam int    V_CODE [NVEC] = '{2, 3, 3, 2, 0, 1, 1, 3, 1};
  localparam int    V_ORD  [NVEC] = '{0, 1, 0, 1, 0, 0, 1, 0, 0};
  localparam int    V_CL   [NVEC] = '{3, 2, 1, 4, 3, 7, 1, 5, 0};
  localparam string V_TAG  [NVEC] = '{"R3", "R4", "R3", "R4", "R6", "R5", "R4", "R2", "R10"};

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_start;
  logic             cmd_stop;
  logic [COL_W-1:0] cmd_col;
  logic [1:0]       cmd_len_code;
  logic             cmd_order;
  logic [2:0]       cas_lat;
  logic             dq_valid;
  logic [COL_W-1:0] dq_col;
  logic             dq_last;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .cmd_stop    (cmd_stop),
    .cmd_col     (cmd_col),
    .cmd_len_code(cmd_len_code),
    .cmd_order   (cmd_order),
    .cas_lat     (cas_lat),
    .dq_valid    (dq_valid),
    .dq_col      (dq_col),
    .dq_last     (dq_last)
  );

  function automatic int exp_col(input int s, input int len, input int ord, input int i);
    int grp;
    int lo;
    grp = s & ~(len - 1);
    if (ord != 0) lo = (s ^ i) & (len - 1);
    else          lo = (s + i) % len;
    return grp | lo;
  endfunction

  task automatic check_out(input logic ev, input int ec, input logic el, input string tag);
    checks++;
    if (dq_valid !== ev || dq_last !== el || (ev && dq_col !== COL_W'(ec))) begin
      fails++;
      $display("FAIL %s: valid=%0b col=%h last=%0b expected valid=%0b col=%h last=%0b",
               tag, dq_valid, dq_col, dq_last, ev, COL_W'(ec), el);
    end
  endtask

  // sample the cycle that just ended, then drive the next cycle's inputs
  task automatic cyc(input logic ev, input int ec, input logic el, input string tag,
                     input logic st, input int col, input int code, input int ord, input logic stp);
    @(negedge clk);
    check_out(ev, ec, el, tag);
    cmd_start    = st;
    cmd_col      = COL_W'(col);
    cmd_len_code = 2'(code);
    cmd_order    = ord[0];
    cmd_stop     = stp;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 0, 1'b0, "idle", 1'b0, 0, 0, 0, 1'b0);
  endtask

  task automatic run_vec(input int col, input int code, input int ord, input int cl, input string tag);
    int len;
    int eff;
    len = 1 << code;
    eff = (cl == 0) ? 1 : cl;
    cas_lat = 3'(cl);
    for (int n = 0; n <= eff + len + 1; n++) begin
      logic ev;
      logic el;
      ev = (n >= eff) && (n < eff + len);
      el = ev && (n - eff == len - 1);
      cyc(ev, ev ? exp_col(col, len, ord, n - eff) : 0, el, tag, (n == 0), col, code, ord, 1'b0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    cmd_start = 1'b0;
    cmd_stop = 1'b0;
    cmd_col = '0;
    cmd_len_code = '0;
    cmd_order = 1'b0;
    cas_lat = 3'd3;
    repeat (3) @(negedge clk);
    check_out(1'b0, 0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    idle(2);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      run_vec(V_COL[v], V_CODE[v], V_ORD[v], V_CL[v], V_TAG[v]);
      idle(2);
    end

    // R7: interrupt at cycle 2 with latency 3
    cas_lat = 3'd3;
    cyc(0, 0, 0, "R7", 1, 0, 3, 0, 0);
    cyc(0, 0, 0, "R7", 0, 0, 3, 0, 0);
    cyc(0, 0, 0, "R7", 1, 'h14, 2, 0, 0);
    cyc(1, 0, 0, "R7", 0, 0, 0, 0, 0);
    cyc(1, 1, 0, "R7", 0, 0, 0, 0, 0);
    cyc(1, 'h14, 0, "R7", 0, 0, 0, 0, 0);
    cyc(1, 'h15, 0, "R7", 0, 0, 0, 0, 0);
    cyc(1, 'h16, 0, "R7", 0, 0, 0, 0, 0);
    cyc(1, 'h17, 1, "R7", 0, 0, 0, 0, 0);
    idle(3);

    // R8: terminate in cycle 3 with latency 2
    cas_lat = 3'd2;
    cyc(0, 0, 0, "R8", 1, 8, 3, 0, 0);
    cyc(0, 0, 0, "R8", 0, 0, 0, 0, 0);
    cyc(1, 8, 0, "R8", 0, 0, 0, 0, 0);
    cyc(1, 9, 0, "R8", 0, 0, 0, 0, 1);
    cyc(1, 10, 0, "R8", 0, 0, 0, 0, 0);
    cyc(0, 0, 0, "R8", 0, 0, 0, 0, 0);
    idle(3);

    // R9: start and stop together, start wins
    cyc(0, 0, 0, "R9", 1, 0, 2, 0, 0);
    cyc(0, 0, 0, "R9", 1, 'h20, 1, 1, 1);
    cyc(1, 0, 0, "R9", 0, 0, 0, 0, 0);
    cyc(1, 'h20, 0, "R9", 0, 0, 0, 0, 0);
    cyc(1, 'h21, 1, "R9", 0, 0, 0, 0, 0);
    cyc(0, 0, 0, "R9", 0, 0, 0, 0, 0);
    idle(2);

    // R1: reset during a burst discards beats in flight
    cas_lat = 3'd1;
    cyc(0, 0, 0, "R1", 1, 0, 3, 0, 0);
    cyc(1, 0, 0, "R1", 0, 0, 0, 0, 0);
    cyc(1, 1, 0, "R1", 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    #1;
    check_out(1'b0, 0, 1'b0, "R1 mid-burst reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    idle(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule